// File: doc/BRIEF.md
# Scheduler Quantum and PC Sampler

This block sits next to a time-sharing kernel's clock and does two jobs on each tick strobe. It keeps a 36-bit run-time accumulator that grows by a fixed quantum step on every tick. The step is skipped on any tick that arrives while a priority interrupt is being serviced. It also performs optional program-counter sampling. A 36-bit sampling pointer holds a negative count in its left half and a buffer address in its right half. While the pointer is negative, each tick captures the current PC and issues a single-word memory write to the address in the right half.

The write is presented as a held request. When the memory accepts it with its ready handshake, both 18-bit halves of the pointer step up by one. The count therefore moves toward zero while the address walks forward. Sampling stops by itself once the left half wraps to zero and the sign bit clears. A host can load the accumulator and the pointer between ticks, and both registers are always visible on output ports.

The quantum step is the time-base rate divided by the tick rate, truncated: 4100000 / 60 = 68333 with the default parameters.

Top module: `sqs_top`

## Requirements
- R1: After a synchronous active-low reset, the accumulator, the pointer and the write request are all zero.
- R2: A tick with `irq_busy_i` low adds 68333 to the accumulator. The new value is visible on `acc_o` in the cycle after the tick.
- R3: The accumulator wraps modulo 2^36. For example, 0xFFFFFFFFF plus one step gives 68332.
- R4: A tick with `irq_busy_i` high leaves the accumulator unchanged.
- R5: On a tick with pointer bit 35 set and no request pending, `mem_req_o` rises in the next cycle. The request carries `mem_addr_o` = pointer bits 17:0 and `mem_data_o` = `pc_i` zero-extended to 36 bits. A tick with bit 35 clear issues no request.
- R6: A pending request keeps `mem_req_o` high, with `mem_addr_o`, `mem_data_o` and the pointer unchanged, until a cycle in which `mem_ack_i` is high. `mem_req_o` is low in the following cycle.
- R7: On acceptance of a write, the pointer becomes {left+1, right+1}. Each 18-bit half wraps on its own, with no carry from the right half into the left half.
- R8: A tick that arrives while a request is pending still updates the accumulator as in R2 and R4. Its sample is dropped, so no further write follows the pending one.
- R9: A host load of the accumulator (`host_ld_acc_i`) takes effect in the next cycle only when no tick is present in that cycle. A host load of the pointer (`host_ld_ptr_i`) takes effect only when no tick is present and no request is pending. Otherwise each load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle clock tick strobe |
| irq_busy_i | input | 1 | High while a priority interrupt is in progress |
| pc_i | input | 18 | Current program counter |
| host_ld_acc_i | input | 1 | Host load strobe for the accumulator |
| host_ld_ptr_i | input | 1 | Host load strobe for the sampling pointer |
| host_wdata_i | input | 36 | Host load data |
| acc_o | output | 36 | Quantum accumulator |
| ptr_o | output | 36 | Sampling pointer (count left, address right) |
| mem_req_o | output | 1 | Memory write request, held until accepted |
| mem_addr_o | output | 18 | Write address |
| mem_data_o | output | 36 | Write data (sampled PC) |
| mem_ack_i | input | 1 | Memory ready; completes the write when high with the request |

## Verification
The accumulator is driven from a table of start values, each paired with a busy or idle interrupt state. Zero and a mid-range value show plain addition. All-ones and a value just below the top show the wrap. Busy entries show the skip. Sampling is tried in three ways. First, a delayed acceptance with extra ticks and a host pointer load during the wait tells a held request apart from a repeated or dropped one. Second, an immediate acceptance that wraps the count half to zero shows the loop ending. Third, a pointer whose address half is all ones shows that the halves do not carry into each other. Host loads made in a tick cycle show that the tick wins.

// File: rtl/sqs_pkg.sv
// Package: shared defaults for the scheduler quantum and PC sampler.
// Assumes the step is an integer quotient of two positive rates.
package sqs_pkg;
    localparam int WORD_W_DEF  = 36;
    localparam int HALF_W_DEF  = 18;
    localparam int TB_RATE_DEF = 4100000;
    localparam int TICK_HZ_DEF = 60;

    // Quantum step per tick: truncated quotient of time-base rate and tick rate.
    function automatic int quantum_step(input int rate, input int hz);
        return rate / hz;
    endfunction
endpackage

// File: rtl/sqs_quantum_acc.sv
// Module: quantum accumulator.
// Adds a fixed step on each tick unless an interrupt is in progress; wraps
// modulo 2^WORD_W. Assumes the host-load request is already qualified by the
// caller only as far as its strobe; a tick always wins over a load.
module sqs_quantum_acc #(
    parameter int WORD_W = 36,
    parameter int STEP   = 68333
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              irq_busy_i,
    input  logic              ld_i,
    input  logic [WORD_W-1:0] ld_data_i,
    output logic [WORD_W-1:0] acc_o
);
    localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP);

    logic [WORD_W-1:0] acc_q;

    // Accumulate on idle ticks; accept host load only between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (tick_i) begin
            if (!irq_busy_i) begin
                acc_q <= acc_q + STEP_W;
            end
        end else if (ld_i) begin
            acc_q <= ld_data_i;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/sqs_sample_ptr.sv
// Module: sampling pointer register.
// Two independent halves; an advance adds one to each half with no carry
// between them. Assumes adv_i and ld_i are never high together.
module sqs_sample_ptr #(
    parameter int HALF_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_i,
    input  logic                ld_i,
    input  logic [2*HALF_W-1:0] ld_data_i,
    output logic [2*HALF_W-1:0] ptr_o
);
    localparam int N_HALVES = 2;

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        logic [HALF_W-1:0] half_q;

        // Per-half register: advance, load or hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (adv_i) begin
                half_q <= half_q + HALF_W'(1);
            end else if (ld_i) begin
                half_q <= ld_data_i[h*HALF_W +: HALF_W];
            end
        end

        assign ptr_o[h*HALF_W +: HALF_W] = half_q;
    end
endmodule

// File: rtl/sqs_wr_port.sv
// Module: single-word memory write port.
// Captures address and PC on a start strobe, holds the request until
// acknowledged, and ignores starts while busy. done_o marks acceptance.
module sqs_wr_port #(
    parameter int HALF_W = 18,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [HALF_W-1:0] addr_i,
    input  logic [HALF_W-1:0] pc_i,
    input  logic              mem_ack_i,
    output logic              req_o,
    output logic [HALF_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o,
    output logic              done_o
);
    localparam int PAD_W = WORD_W - HALF_W;

    logic              req_q;
    logic [HALF_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;

    // Request holding: complete on ack, otherwise accept a new start when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (req_q) begin
            if (mem_ack_i) begin
                req_q <= 1'b0;
            end
        end else if (start_i) begin
            req_q  <= 1'b1;
            addr_q <= addr_i;
            data_q <= {{PAD_W{1'b0}}, pc_i};
        end
    end

    assign req_o  = req_q;
    assign addr_o = addr_q;
    assign data_o = data_q;
    assign done_o = req_q & mem_ack_i;
endmodule

// File: rtl/sqs_top.sv
// Module: scheduler quantum and PC sampler top.
// Ties the accumulator, pointer and write port together. Assumes tick_i is
// a single-cycle strobe and that memory holds mem_ack_i meaningful only
// while mem_req_o is high.
module sqs_top #(
    parameter int WORD_W  = sqs_pkg::WORD_W_DEF,
    parameter int HALF_W  = sqs_pkg::HALF_W_DEF,
    parameter int TB_RATE = sqs_pkg::TB_RATE_DEF,
    parameter int TICK_HZ = sqs_pkg::TICK_HZ_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              irq_busy_i,
    input  logic [HALF_W-1:0] pc_i,
    input  logic              host_ld_acc_i,
    input  logic              host_ld_ptr_i,
    input  logic [WORD_W-1:0] host_wdata_i,
    output logic [WORD_W-1:0] acc_o,
    output logic [WORD_W-1:0] ptr_o,
    output logic              mem_req_o,
    output logic [HALF_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_data_o,
    input  logic              mem_ack_i
);
    localparam int STEP = sqs_pkg::quantum_step(TB_RATE, TICK_HZ);

    logic sign_w;
    logic start_w;
    logic done_w;
    logic ptr_ld_w;

    // Sampling is armed by the pointer's sign bit.
    assign sign_w   = ptr_o[WORD_W-1];
    assign start_w  = tick_i & sign_w;
    // Pointer load only between ticks and with no write outstanding.
    assign ptr_ld_w = host_ld_ptr_i & ~tick_i & ~mem_req_o;

    sqs_quantum_acc #(.WORD_W(WORD_W), .STEP(STEP)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .irq_busy_i(irq_busy_i),
        .ld_i      (host_ld_acc_i),
        .ld_data_i (host_wdata_i),
        .acc_o     (acc_o)
    );

    sqs_sample_ptr #(.HALF_W(HALF_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (done_w),
        .ld_i     (ptr_ld_w),
        .ld_data_i(host_wdata_i),
        .ptr_o    (ptr_o)
    );

    sqs_wr_port #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .addr_i   (ptr_o[HALF_W-1:0]),
        .pc_i     (pc_i),
        .mem_ack_i(mem_ack_i),
        .req_o    (mem_req_o),
        .addr_o   (mem_addr_o),
        .data_o   (mem_data_o),
        .done_o   (done_w)
    );
endmodule

// File: rtl/sqs_checker.sv
// Module: property checker for sqs_top, attached by bind.
// Assumes the default 2*HALF_W == WORD_W pointer layout.
module sqs_checker #(
    parameter int WORD_W = 36,
    parameter int HALF_W = 18,
    parameter int STEP   = 68333
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              irq_busy_i,
    input logic [HALF_W-1:0] pc_i,
    input logic [WORD_W-1:0] acc_o,
    input logic [WORD_W-1:0] ptr_o,
    input logic              mem_req_o,
    input logic [HALF_W-1:0] mem_addr_o,
    input logic [WORD_W-1:0] mem_data_o,
    input logic              mem_ack_i
);
    localparam int PAD_W = WORD_W - HALF_W;

    // R2 R3: idle tick adds the step modulo 2^WORD_W
    p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !irq_busy_i) |=> acc_o == WORD_W'($past(acc_o) + WORD_W'(STEP)));

    // R4: busy tick leaves the accumulator alone
    p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && irq_busy_i) |=> $stable(acc_o));

    // R5: armed idle tick launches a write of the PC to the right half
    p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !mem_req_o && ptr_o[WORD_W-1]) |=>
        (mem_req_o && mem_addr_o == $past(ptr_o[HALF_W-1:0])
         && mem_data_o == {{PAD_W{1'b0}}, $past(pc_i)}));

    // R5: unarmed idle port stays idle on a tick
    p_no_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !mem_req_o && !ptr_o[WORD_W-1]) |=> !mem_req_o);

    // R6: held request is stable until accepted
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o) && $stable(ptr_o)));

    // R6 R7: acceptance drops the request and steps both halves
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=>
        (!mem_req_o
         && ptr_o[HALF_W-1:0] == HALF_W'($past(ptr_o[HALF_W-1:0]) + HALF_W'(1))
         && ptr_o[WORD_W-1:HALF_W] == HALF_W'($past(ptr_o[WORD_W-1:HALF_W]) + HALF_W'(1))));
endmodule

bind sqs_top sqs_checker #(
    .WORD_W(WORD_W),
    .HALF_W(HALF_W),
    .STEP  (STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .irq_busy_i(irq_busy_i),
    .pc_i      (pc_i),
    .acc_o     (acc_o),
    .ptr_o     (ptr_o),
    .mem_req_o (mem_req_o),
    .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o),
    .mem_ack_i (mem_ack_i)
);

// File: tb/tb_sqs_top.sv
module tb_sqs_top;
    localparam int W = 36;
    localparam int H = 18;
    localparam logic [W-1:0] STEP = 36'd68333;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         irq_busy_i = 1'b0;
    logic [H-1:0] pc_i = '0;
    logic         host_ld_acc_i = 1'b0;
    logic         host_ld_ptr_i = 1'b0;
    logic [W-1:0] host_wdata_i = '0;
    logic [W-1:0] acc_o;
    logic [W-1:0] ptr_o;
    logic         mem_req_o;
    logic [H-1:0] mem_addr_o;
    logic [W-1:0] mem_data_o;
    logic         mem_ack_i = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sqs_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .irq_busy_i(irq_busy_i),
        .pc_i(pc_i), .host_ld_acc_i(host_ld_acc_i), .host_ld_ptr_i(host_ld_ptr_i),
        .host_wdata_i(host_wdata_i), .acc_o(acc_o), .ptr_o(ptr_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .mem_ack_i(mem_ack_i)
    );

    // {irq_busy, start value, expected accumulator after one tick}
    localparam logic [72:0] VEC [0:5] = '{
        {1'b0, 36'd0,           36'd68333},
        {1'b1, 36'd0,           36'd0},
        {1'b0, 36'hFFFFFFFFF,   36'd68332},
        {1'b0, 36'hFFFFF0000,   36'd2797},
        {1'b1, 36'd1000,        36'd1000},
        {1'b0, 36'h123456789,   36'h123467276}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_acc(input logic [W-1:0] v);
        host_wdata_i = v; host_ld_acc_i = 1'b1; step(); host_ld_acc_i = 1'b0;
    endtask

    task automatic load_ptr(input logic [W-1:0] v);
        host_wdata_i = v; host_ld_ptr_i = 1'b1; step(); host_ld_ptr_i = 1'b0;
    endtask

    task automatic tick(input logic busy);
        irq_busy_i = busy; tick_i = 1'b1; step(); tick_i = 1'b0; irq_busy_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 acc", acc_o, '0);
        chk("R1 ptr", ptr_o, '0);
        chk("R1 req", {35'd0, mem_req_o}, 36'd0);

        // Table: R2 R3 R4 accumulator behaviour
        for (int i = 0; i < 6; i++) begin
            load_acc(VEC[i][71:36]);
            tick(VEC[i][72]);
            chk(VEC[i][72] ? "R4 busy skip" : "R2 R3 step", acc_o, VEC[i][35:0]);
            chk("R5 no request when ptr positive", {35'd0, mem_req_o}, 36'd0);
        end

        // R5 launch with delayed acceptance
        load_ptr({18'h3FFFE, 18'h00100});
        pc_i = 18'h01234;
        tick(1'b0);
        chk("R5 req", {35'd0, mem_req_o}, 36'd1);
        chk("R5 addr", {18'd0, mem_addr_o}, 36'h100);
        chk("R5 data", mem_data_o, 36'h1234);
        pc_i = 18'h2AAAA;
        step(); step();
        chk("R6 req held", {35'd0, mem_req_o}, 36'd1);
        chk("R6 data stable", mem_data_o, 36'h1234);
        // R8 tick while pending: counted, sample dropped
        a0 = acc_o;
        tick(1'b0);
        chk("R8 acc counted", acc_o, a0 + STEP);
        chk("R8 addr unchanged", {18'd0, mem_addr_o}, 36'h100);
        // R9 pointer load ignored while pending
        load_ptr(36'h0);
        chk("R9 ptr load ignored pending", ptr_o, {18'h3FFFE, 18'h00100});
        // R7 acceptance
        mem_ack_i = 1'b1; step(); mem_ack_i = 1'b0;
        chk("R6 req dropped", {35'd0, mem_req_o}, 36'd0);
        chk("R7 advance", ptr_o, {18'h3FFFF, 18'h00101});
        step(); step();
        chk("R8 no second write", {35'd0, mem_req_o}, 36'd0);

        // R7 immediate acceptance, count half wraps to zero
        tick(1'b0);
        chk("R5 addr second", {18'd0, mem_addr_o}, 36'h101);
        mem_ack_i = 1'b1; step(); mem_ack_i = 1'b0;
        chk("R7 left wrap", ptr_o, {18'h00000, 18'h00102});
        tick(1'b0);
        chk("R5 sampling ended", {35'd0, mem_req_o}, 36'd0);

        // R7 no carry between halves
        load_ptr({18'h20000, 18'h3FFFF});
        tick(1'b0);
        mem_ack_i = 1'b1; step(); mem_ack_i = 1'b0;
        chk("R7 no carry", ptr_o, {18'h20001, 18'h00000});

        // R9 host loads ignored in a tick cycle
        load_ptr(36'h000000005);
        load_acc(36'd50);
        host_wdata_i = 36'd999; host_ld_acc_i = 1'b1; host_ld_ptr_i = 1'b1; tick_i = 1'b1;
        step();
        host_ld_acc_i = 1'b0; host_ld_ptr_i = 1'b0; tick_i = 1'b0;
        chk("R9 acc load loses to tick", acc_o, 36'd50 + STEP);
        chk("R9 ptr load loses to tick", ptr_o, 36'h000000005);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule